// File: doc/BRIEF.md
# Packed Unsigned-Halfword to Half-Precision Converter

This block turns a vector of unsigned 16-bit integer lanes into IEEE 754 half-precision values. It has one register stage. The active vector width is 128, 256 or 512 bits, which gives 8, 16 or 32 lanes. Each active lane goes through a rounder. The rounder keeps 11 significant bits and rounds the discarded bits with a guard bit and a sticky bit, under one of four rounding modes.

Control logic around the rounder does three jobs:
- It picks the rounding mode. The mode comes either from a field carried with the operation or from a global field, depending on where the operand came from and on the vector width.
- It can replicate lane 0 of a memory operand into every lane.
- It applies a per-lane write mask. A lane whose mask bit is clear is either zeroed or keeps its old destination value.

Two sticky flags, overflow and precision, collect exceptions from the lanes that were written. They stay set until reset. Raising traps from these flags is left to the surrounding logic.

Top module: `cvt_u16_fp16`

## Requirements
- R1: `vl_sel` picks the active width: 0 gives 8 lanes (128 bits), 1 gives 16 lanes (256 bits), 2 or 3 gives 32 lanes (512 bits). Lane j occupies bits [16j+15:16j]. Destination bits above the active width are written as zero.
- R2: A written lane holds the half-precision encoding of its source word. 0 gives 0x0000. Every value up to 2048 is exact (1 gives 0x3C00, 2048 gives 0x6800). Larger values keep 11 significant bits.
- R3: The rounding-mode encoding is 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. Under nearest-even an exact tie rounds to the even significand (2049 gives 0x6800, 2051 gives 0x6802). Under toward plus infinity any discarded bit rounds up (2049 gives 0x6801). Toward zero and toward minus infinity truncate.
- R4: A result that rounds above 65504 becomes +infinity (0x7C00) and sets both the overflow flag and the precision flag. Under toward zero or toward minus infinity, large inputs such as 65535 give 0x7BFF and set only the precision flag.
- R5: The precision flag is set by a written lane whose conversion is inexact. Exact conversions leave it clear.
- R6: `emb_rm` is the rounding mode when the source is a register (`src_is_mem`=0), the width is 512 bits and `bcast`=1. In every other case `glob_rm` is used.
- R7: With `src_is_mem`=1 and `bcast`=1, every lane converts source bits [15:0]. With a register source, `bcast` does not replicate.
- R8: A lane is written with its converted value when `mask_en`=0 or its bit in `wmask` is 1.
- R9: An active lane that is not written is cleared to zero when `zeroing`=1. When `zeroing`=0 it takes its value from `old_dst`.
- R10: Flags are ORed only over active, written lanes. Both flags are sticky until reset.
- R11: During reset the destination output and both flags are zero.
- R12: All outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vec | input | MAX_VL (512) | Packed unsigned 16-bit source lanes |
| src_is_mem | input | 1 | Source operand came from memory |
| bcast | input | 1 | Broadcast / embedded-rounding control bit |
| emb_rm | input | 2 | Rounding mode carried with the operation |
| glob_rm | input | 2 | Global rounding mode |
| vl_sel | input | 2 | Active vector width select |
| wmask | input | MAX_VL/16 (32) | Per-lane write mask |
| mask_en | input | 1 | Write mask in use |
| zeroing | input | 1 | 1 zeroes unwritten lanes, 0 merges from old_dst |
| old_dst | input | MAX_VL (512) | Previous destination contents |
| dst_out | output | MAX_VL (512) | Registered result vector |
| ovf_flag | output | 1 | Sticky overflow flag |
| prec_flag | output | 1 | Sticky precision (inexact) flag |

## Verification
The result vector and both flags sit behind a single register, so inputs presented before a rising edge show up at the outputs just after that edge. The bench drives each operation on the falling edge. Just before the next rising edge it checks that the outputs still show the previous result. Just after that edge it compares them against a behavioural model of the new inputs. The model also carries the sticky flags from cycle to cycle, so a flag raised in one cycle is still expected in every later cycle until a reset clears it.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    localparam int LANE_W = 16;
    localparam int HEXP_W = 5;
    localparam int HMAN_W = 10;
    localparam int HBIAS  = 15;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_ZERO      = 2'b11
    } rmode_e;

    typedef struct packed {
        logic [LANE_W-1:0] bits;
        logic              ovf;
        logic              inx;
    } lane_res_t;

endpackage

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
    import cvt_pkg::*;
#(
    parameter int LANES  = 32,
    localparam int CNT_W = $clog2(LANES) + 1
) (
    input  logic             src_is_mem,
    input  logic             bcast,
    input  logic [1:0]       emb_rm,
    input  logic [1:0]       glob_rm,
    input  logic [1:0]       vl_sel,
    output rmode_e           rm,
    output logic             use_word0,
    output logic [CNT_W-1:0] active_lanes
);
    logic full_width;

    always_comb begin
        full_width = vl_sel[1];
        case (vl_sel)
            2'b00:   active_lanes = CNT_W'(LANES / 4);
            2'b01:   active_lanes = CNT_W'(LANES / 2);
            default: active_lanes = CNT_W'(LANES);
        endcase
        if (!src_is_mem && full_width && bcast) begin
            rm = rmode_e'(emb_rm);
        end else begin
            rm = rmode_e'(glob_rm);
        end
        use_word0 = src_is_mem && bcast;
    end

endmodule

// File: rtl/cvt_lane.sv
module cvt_lane
    import cvt_pkg::*;
(
    input  logic [LANE_W-1:0] val,
    input  rmode_e            rm,
    output lane_res_t         res
);
    logic [3:0]        msb;
    logic [LANE_W-1:0] norm;
    logic [HMAN_W:0]   kept;
    logic              guard;
    logic              sticky;
    logic              inexact;
    logic              up;
    logic [HMAN_W+1:0] sum;
    logic [HEXP_W-1:0] exp_f;
    logic [HMAN_W-1:0] man_f;

    always_comb begin
        msb = 4'd0;
        for (int i = 0; i < LANE_W; i++) begin
            if (val[i]) msb = 4'(i);
        end
        norm    = val << (4'd15 - msb);
        kept    = norm[LANE_W-1:LANE_W-HMAN_W-1];
        guard   = norm[4];
        sticky  = |norm[3:0];
        inexact = guard | sticky;
        case (rm)
            RM_NEAR_EVEN: up = guard & (sticky | kept[0]);
            RM_UP:        up = inexact;
            default:      up = 1'b0;
        endcase
        sum   = {1'b0, kept} + (HMAN_W+2)'(up);
        exp_f = {1'b0, msb} + HEXP_W'(HBIAS) + HEXP_W'(sum[HMAN_W+1]);
        man_f = sum[HMAN_W+1] ? '0 : sum[HMAN_W-1:0];
        if (val == '0) begin
            res = '0;
        end else begin
            res.bits = {1'b0, exp_f, man_f};
            res.ovf  = (exp_f == '1);
            res.inx  = inexact | (exp_f == '1);
        end
    end

endmodule

// File: rtl/cvt_u16_fp16.sv
module cvt_u16_fp16
    import cvt_pkg::*;
#(
    parameter  int MAX_VL = 512,
    localparam int LANES  = MAX_VL / LANE_W,
    localparam int CNT_W  = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_VL-1:0] src_vec,
    input  logic              src_is_mem,
    input  logic              bcast,
    input  logic [1:0]        emb_rm,
    input  logic [1:0]        glob_rm,
    input  logic [1:0]        vl_sel,
    input  logic [LANES-1:0]  wmask,
    input  logic              mask_en,
    input  logic              zeroing,
    input  logic [MAX_VL-1:0] old_dst,
    output logic [MAX_VL-1:0] dst_out,
    output logic              ovf_flag,
    output logic              prec_flag
);
    typedef struct packed {
        logic [MAX_VL-1:0] dst;
        logic              ovf;
        logic              prec;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    rmode_e            rm;
    logic              use_word0;
    logic [CNT_W-1:0]  active_lanes;
    logic [LANE_W-1:0] lane_val [LANES];
    lane_res_t         lane_res [LANES];

    cvt_ctrl #(.LANES(LANES)) u_ctrl (
        .src_is_mem   (src_is_mem),
        .bcast        (bcast),
        .emb_rm       (emb_rm),
        .glob_rm      (glob_rm),
        .vl_sel       (vl_sel),
        .rm           (rm),
        .use_word0    (use_word0),
        .active_lanes (active_lanes)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_val[j] = use_word0 ? src_vec[LANE_W-1:0]
                                       : src_vec[j*LANE_W +: LANE_W];
        cvt_lane u_lane (
            .val (lane_val[j]),
            .rm  (rm),
            .res (lane_res[j])
        );
    end

    always_comb begin
        logic any_ovf;
        logic any_inx;
        any_ovf = 1'b0;
        any_inx = 1'b0;
        st_d     = st_q;
        st_d.dst = '0;
        for (int j = 0; j < LANES; j++) begin
            if (CNT_W'(j) < active_lanes) begin
                if (!mask_en || wmask[j]) begin
                    st_d.dst[j*LANE_W +: LANE_W] = lane_res[j].bits;
                    any_ovf = any_ovf | lane_res[j].ovf;
                    any_inx = any_inx | lane_res[j].inx;
                end else if (!zeroing) begin
                    st_d.dst[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
                end
            end
        end
        st_d.ovf  = st_q.ovf | any_ovf;
        st_d.prec = st_q.prec | any_inx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_out   = st_q.dst;
    assign ovf_flag  = st_q.ovf;
    assign prec_flag = st_q.prec;

endmodule

// File: rtl/cvt_u16_fp16_chk.sv
module cvt_u16_fp16_chk #(
    parameter  int MAX_VL = 512,
    localparam int LANES  = MAX_VL / 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        vl_sel,
    input logic [LANES-1:0]  wmask,
    input logic              mask_en,
    input logic              zeroing,
    input logic [MAX_VL-1:0] old_dst,
    input logic [MAX_VL-1:0] dst_out,
    input logic              ovf_flag,
    input logic              prec_flag
);
    p_upper_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_sel == 2'b00) |=> (dst_out[MAX_VL-1:MAX_VL/4] == '0));

    p_upper_clear_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_sel == 2'b01) |=> (dst_out[MAX_VL-1:MAX_VL/2] == '0));

    p_ovf_has_prec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> prec_flag);

    p_zero_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && zeroing && wmask == '0) |=> (dst_out == '0));

    p_merge_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && !zeroing && wmask == '0 && vl_sel[1]) |=> (dst_out == $past(old_dst)));

    p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_sticky_prec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prec_flag |=> prec_flag);

    p_masked_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && wmask == '0) |=> (prec_flag == $past(prec_flag)));

endmodule

bind cvt_u16_fp16 cvt_u16_fp16_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vl_sel    (vl_sel),
    .wmask     (wmask),
    .mask_en   (mask_en),
    .zeroing   (zeroing),
    .old_dst   (old_dst),
    .dst_out   (dst_out),
    .ovf_flag  (ovf_flag),
    .prec_flag (prec_flag)
);

// File: tb/tb_cvt_u16_fp16.sv
module tb_cvt_u16_fp16;
    localparam int CLK_PERIOD = 10;
    localparam int VL = 512;
    localparam int NL = VL / 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VL-1:0] src_vec = '0;
    logic          src_is_mem = 1'b0;
    logic          bcast = 1'b0;
    logic [1:0]    emb_rm = 2'd0;
    logic [1:0]    glob_rm = 2'd0;
    logic [1:0]    vl_sel = 2'd2;
    logic [NL-1:0] wmask = '0;
    logic          mask_en = 1'b0;
    logic          zeroing = 1'b0;
    logic [VL-1:0] old_dst = '0;
    logic [VL-1:0] dst_out;
    logic          ovf_flag;
    logic          prec_flag;

    int checks = 0;
    int errors = 0;
    logic [VL-1:0] exp_dst = '0;
    logic          exp_ovf = 1'b0;
    logic          exp_prec = 1'b0;

    cvt_u16_fp16 #(.MAX_VL(VL)) dut (
        .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .src_is_mem(src_is_mem),
        .bcast(bcast), .emb_rm(emb_rm), .glob_rm(glob_rm), .vl_sel(vl_sel),
        .wmask(wmask), .mask_en(mask_en), .zeroing(zeroing), .old_dst(old_dst),
        .dst_out(dst_out), .ovf_flag(ovf_flag), .prec_flag(prec_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] ref_conv(input int v, input int mode,
                                             output logic o, output logic x);
        int e, ulp, q, r, up, rv, re, man;
        o = 1'b0; x = 1'b0;
        if (v == 0) return 16'h0000;
        e = 0;
        while ((1 << (e + 1)) <= v) e++;
        ulp = (e > 10) ? (1 << (e - 10)) : 1;
        q = v / ulp; r = v % ulp;
        x = (r != 0);
        up = 0;
        if (mode == 0) up = (2*r > ulp || (2*r == ulp && r != 0 && q % 2 == 1)) ? 1 : 0;
        if (mode == 2) up = (r != 0) ? 1 : 0;
        rv = (q + up) * ulp;
        if (rv > 65504) begin
            o = 1'b1; x = 1'b1;
            return 16'h7C00;
        end
        re = (rv >= (1 << (e + 1))) ? e + 1 : e;
        man = (re >= 10) ? rv / (1 << (re - 10)) - 1024 : rv * (1 << (10 - re)) - 1024;
        return 16'((re + 15) * 1024 + man);
    endfunction

    task automatic predict();
        int n, mode;
        logic o, x;
        logic [15:0] w;
        n = (vl_sel == 2'd0) ? 8 : (vl_sel == 2'd1) ? 16 : 32;
        mode = (!src_is_mem && vl_sel >= 2 && bcast) ? int'(emb_rm) : int'(glob_rm);
        exp_dst = '0;
        for (int j = 0; j < n; j++) begin
            w = (src_is_mem && bcast) ? src_vec[15:0] : src_vec[16*j +: 16];
            if (!mask_en || wmask[j]) begin
                exp_dst[16*j +: 16] = ref_conv(int'(w), mode, o, x);
                exp_ovf  = exp_ovf | o;
                exp_prec = exp_prec | x;
            end else if (!zeroing) begin
                exp_dst[16*j +: 16] = old_dst[16*j +: 16];
            end
        end
    endtask

    task automatic chk_vec(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s dst actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic chk_lane(input string tag, input int j, input logic [15:0] expv);
        checks++;
        if (dst_out[16*j +: 16] !== expv) begin
            errors++;
            $display("FAIL %s lane %0d actual=%h expected=%h", tag, j, dst_out[16*j +: 16], expv);
        end
    endtask

    // inputs already driven after a falling edge; outputs due after the next rising edge
    task automatic step(input string tag);
        #1;
        chk_vec({tag, " R12 hold"}, dst_out, exp_dst);
        predict();
        @(posedge clk);
        #1;
        chk_vec(tag, dst_out, exp_dst);
        chk_bit({tag, " R10 ovf"}, ovf_flag, exp_ovf);
        chk_bit({tag, " R10 prec"}, prec_flag, exp_prec);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_dst = '0; exp_ovf = 1'b0; exp_prec = 1'b0;
        chk_vec("R11 reset", dst_out, '0);
        chk_bit("R11 reset ovf", ovf_flag, 1'b0);
        chk_bit("R11 reset prec", prec_flag, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic defaults();
        src_vec = '0; src_is_mem = 0; bcast = 0; emb_rm = 0; glob_rm = 0;
        vl_sel = 2; wmask = '0; mask_en = 0; zeroing = 0; old_dst = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 exact values, R3 nearest-even ties
        defaults();
        src_vec[15:0] = 16'd0;   src_vec[31:16] = 16'd1;
        src_vec[47:32] = 16'd2048; src_vec[63:48] = 16'd2049;
        src_vec[79:64] = 16'd2051; src_vec[95:80] = 16'd1000;
        step("R2 R3 nearest");
        chk_lane("R2 zero", 0, 16'h0000);
        chk_lane("R2 one", 1, 16'h3C00);
        chk_lane("R2 2048", 2, 16'h6800);
        chk_lane("R3 tie even", 3, 16'h6800);
        chk_lane("R3 tie odd", 4, 16'h6802);
        chk_bit("R5 inexact", prec_flag, 1'b1);

        // R4 overflow under nearest
        do_reset();
        src_vec = '0; src_vec[15:0] = 16'hFFFF; src_vec[31:16] = 16'd65519;
        step("R4 ovf near");
        chk_lane("R4 inf", 0, 16'h7C00);
        chk_lane("R4 below", 1, 16'h7BFF);
        chk_bit("R4 ovf set", ovf_flag, 1'b1);

        // R4 saturate under toward-zero, R3 up-rounding
        do_reset();
        defaults(); glob_rm = 2'd3; src_vec[15:0] = 16'hFFFF;
        step("R4 sat rz");
        chk_lane("R4 sat", 0, 16'h7BFF);
        chk_bit("R4 no ovf", ovf_flag, 1'b0);
        glob_rm = 2'd1; step("R4 sat rd");
        glob_rm = 2'd2; src_vec[15:0] = 16'd2049;
        step("R3 up");
        chk_lane("R3 up 2049", 0, 16'h6801);

        // R5 exact only
        do_reset();
        defaults();
        for (int j = 0; j < NL; j++) src_vec[16*j +: 16] = 16'(j * 64);
        step("R5 exact");
        chk_bit("R5 prec clear", prec_flag, 1'b0);

        // R6 rounding source selection
        do_reset();
        defaults(); src_vec[15:0] = 16'd2049; emb_rm = 2'd2; glob_rm = 2'd3; bcast = 1;
        step("R6 emb");
        chk_lane("R6 emb used", 0, 16'h6801);
        vl_sel = 2'd1; step("R6 narrow glob");
        chk_lane("R6 glob used", 0, 16'h6800);
        vl_sel = 2'd2; src_is_mem = 1; step("R6 mem glob");
        chk_lane("R6 mem glob", 5, 16'h6800);

        // R7 broadcast
        defaults(); src_is_mem = 1; bcast = 1;
        src_vec[15:0] = 16'd3; src_vec[31:16] = 16'd7;
        step("R7 bcast");
        chk_lane("R7 bcast lane1", 1, 16'h4200);
        src_is_mem = 0; vl_sel = 2'd3; step("R7 reg no bcast");
        chk_lane("R7 reg lane1", 1, 16'h4700);

        // R8 R9 masking
        defaults();
        for (int j = 0; j < NL; j++) src_vec[16*j +: 16] = 16'(j + 1);
        old_dst = {VL{1'b1}}; mask_en = 1; wmask = 32'hA5A5_0F0F;
        step("R8 R9 merge");
        zeroing = 1; step("R8 R9 zero");
        mask_en = 0; step("R8 mask off");

        // R1 widths, upper bits cleared
        zeroing = 0; mask_en = 1; wmask = '0;
        vl_sel = 2'd0; step("R1 128 merge");
        vl_sel = 2'd1; step("R1 256 merge");
        mask_en = 0; vl_sel = 2'd0; step("R1 128 write");

        // R10 masked and inactive lanes raise no flags
        do_reset();
        defaults(); src_vec = {VL{1'b1}}; mask_en = 1; wmask = 32'h0000_0000;
        step("R10 masked");
        chk_bit("R10 masked no ovf", ovf_flag, 1'b0);
        src_vec = '0; src_vec[VL-1 -: 16] = 16'hFFFF; vl_sel = 2'd0; mask_en = 0;
        step("R10 inactive");
        chk_bit("R10 inactive no prec", prec_flag, 1'b0);

        // random patterns
        for (int i = 0; i < 600; i++) begin
            if (i % 60 == 0) do_reset();
            for (int j = 0; j < NL; j++) begin
                src_vec[16*j +: 16] = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 4096))
                                                                   : 16'($urandom);
                old_dst[16*j +: 16] = 16'($urandom);
            end
            src_is_mem = 1'($urandom); bcast = 1'($urandom);
            emb_rm = 2'($urandom); glob_rm = 2'($urandom); vl_sel = 2'($urandom);
            wmask = $urandom; mask_en = 1'($urandom); zeroing = 1'($urandom);
            step("R1 R2 R3 R6 R7 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule